// File: doc/BRIEF.md
# Clock Frequency Change Sequencer

This block sets the core and peripheral clock rates of a chip from one software-written frequency control word. The word carries a PLL multiplier select and two divider selects, one for the core clock enable and one for the peripheral clock enable. Each divider turns a base clock into a clock-enable strobe that fires once every N base cycles.

When a write changes only the divider selects, the new ratios apply on the same clock edge and the processor keeps running. When a write changes the multiplier select, the block enters a settling pause. Both clock enables are held low, the processor stall is raised, and an 8-bit up-counter starts from a start value set by software. The counter advances on a prescaled tick. When it wraps from 0xFF to 0x00, the block applies the new multiplier and the new divider selects together, drops the stall, stops the counter and raises a one-cycle done strobe. The external clock output enable stays high the whole time. Software sets the counter start value and the prescaler select beforehand through a second write address.

The controller is a two-state machine. In RUN the clocks run and the block accepts writes. In SETTLE the clocks are gated and the block waits for the counter to wrap. The transition RUN to SETTLE is taken on a frequency write whose multiplier field differs from the one in force. The transition SETTLE to RUN is taken on counter wrap.

Top module: `clk_rate_seq`

## Requirements
- R1: After reset pll_mul is 2'b00 (multiply by 1), the core divider select is 2'b00 and the peripheral divider select is 2'b11, so core_ce fires every cycle and peri_ce fires every 4th cycle. cpu_stall, busy and done are 0.
- R2: A divider select value s gives one enable strobe every s+1 base cycles (00 = /1, 01 = /2, 10 = /3, 11 = /4), so there are exactly 12/(s+1) strobes in any 12 consecutive cycles.
- R3: A write to address 0 whose multiplier field equals the current pll_mul applies the core divider field (bits 3:2) and the peripheral divider field (bits 5:4) at that clock edge. cpu_stall stays 0.
- R4: A write to address 0 whose multiplier field (bits 1:0) differs from pll_mul raises cpu_stall and busy in the next cycle. While cpu_stall is high, core_ce and peri_ce stay 0.
- R5: The pause lasts exactly (256 - start) * 4^k cycles. start is bits 7:0 and k is bits 10:8 of the last write to address 1 made before the pause began.
- R6: When the counter wraps, cpu_stall and busy fall, pll_mul and both divider selects take the values from the pausing write, and done is high for exactly that one cycle.
- R7: Writes to either address while busy is high have no effect on the settings being applied or on the next pause length.
- R8: pll_mul changes only in a cycle where done is high, and it keeps the old value during the pause.
- R9: clkout_en stays 1 at all times, including during the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = frequency control word, 1 = settle counter setup |
| wr_data | input | 16 | Write data |
| core_ce | output | 1 | Core clock enable strobe |
| peri_ce | output | 1 | Peripheral clock enable strobe |
| cpu_stall | output | 1 | Processor stall during the settling pause |
| busy | output | 1 | Pause in progress |
| done | output | 1 | One-cycle strobe when new settings apply |
| pll_mul | output | 2 | Multiplier select driven to the PLL |
| clkout_en | output | 1 | External clock output enable |

## Verification
The bench uses the default parameters: an 8-bit settle counter and a 3-bit prescaler select. With these, every prescale step from /1 up to /16384 and start values from 0x00 to 0xFF are reachable within a short run. The vector table covers the shortest pause (start 0xFF at /1, a single cycle), a full 256-tick count at /16, and the largest prescaler. For each vector it checks the pause length, gating, strobe rates after resume and the multiplier hold. Directed tests cover writes during a pause and a divider-only change.

// File: rtl/clk_rate_seq_pkg.sv
package clk_rate_seq_pkg;
    localparam int MUL_W = 2;
    localparam int DIV_W = 2;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SETTLE = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic [MUL_W-1:0] mul;
        logic [DIV_W-1:0] cdiv;
        logic [DIV_W-1:0] pdiv;
    } freq_cfg_t;
endpackage

// File: rtl/rate_divider.sv
module rate_divider #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    input  logic             hold,
    output logic             ce
);
    logic [SEL_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (restart || hold)  cnt <= '0;
        else if (cnt >= sel)       cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    assign ce = !hold && (cnt == '0);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int CNT_W  = 8,
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [CNT_W-1:0]  start_val,
    input  logic [PSEL_W-1:0] psel,
    output logic              ovf
);
    localparam int PRE_W = 2 * ((1 << PSEL_W) - 1);

    logic [CNT_W-1:0]  cnt;
    logic [PRE_W-1:0]  pre;
    logic [PSEL_W-1:0] psel_q;
    logic [PRE_W-1:0]  mask;
    logic              tick;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < 2 * int'(psel_q));
        end
    end

    assign tick = run && (pre == mask);
    assign ovf  = tick && (cnt == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            pre    <= '0;
            psel_q <= '0;
        end else if (load) begin
            cnt    <= start_val;
            pre    <= '0;
            psel_q <= psel;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
            pre <= '0;
        end else if (run) begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/clk_rate_seq.sv
module clk_rate_seq
    import clk_rate_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              core_ce,
    output logic              peri_ce,
    output logic              cpu_stall,
    output logic              busy,
    output logic              done,
    output logic [MUL_W-1:0]  pll_mul,
    output logic              clkout_en
);
    localparam int CDIV_LSB = MUL_W;
    localparam int PDIV_LSB = MUL_W + DIV_W;
    localparam int PSEL_LSB = CNT_W;
    localparam freq_cfg_t CFG_RST = '{mul: '0, cdiv: '0, pdiv: '1};

    seq_state_t        state, state_nx;
    freq_cfg_t         act_cfg, pend_cfg, wr_cfg;
    logic [CNT_W-1:0]  wd_start;
    logic [PSEL_W-1:0] wd_psel;
    logic              freq_wr, mul_chg, ovf, div_restart, settling;
    logic [DIV_W-1:0]  div_sel [2];
    logic [1:0]        ce_vec;

    assign wr_cfg.mul  = wr_data[MUL_W-1:0];
    assign wr_cfg.cdiv = wr_data[CDIV_LSB +: DIV_W];
    assign wr_cfg.pdiv = wr_data[PDIV_LSB +: DIV_W];

    assign freq_wr     = wr_en && !wr_addr && (state == ST_RUN);
    assign mul_chg     = freq_wr && (wr_cfg.mul != act_cfg.mul);
    assign settling    = (state == ST_SETTLE);
    assign div_restart = (freq_wr && !mul_chg) || ovf;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (mul_chg) state_nx = ST_SETTLE;
            ST_SETTLE: if (ovf)     state_nx = ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        cpu_stall = 1'b0;
        busy      = 1'b0;
        unique case (state)
            ST_RUN:    ;
            ST_SETTLE: begin
                cpu_stall = 1'b1;
                busy      = 1'b1;
            end
            default:   ;
        endcase
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cfg  <= CFG_RST;
            pend_cfg <= CFG_RST;
            wd_start <= '0;
            wd_psel  <= '0;
            done     <= 1'b0;
        end else begin
            done <= ovf;
            if (wr_en && wr_addr && !settling) begin
                wd_start <= wr_data[CNT_W-1:0];
                wd_psel  <= wr_data[PSEL_LSB +: PSEL_W];
            end
            if (mul_chg)      pend_cfg <= wr_cfg;
            else if (freq_wr) act_cfg  <= wr_cfg;
            if (ovf)          act_cfg  <= pend_cfg;
        end
    end

    settle_timer #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(mul_chg), .run(settling),
        .start_val(wd_start), .psel(wd_psel), .ovf(ovf)
    );

    assign div_sel[0] = act_cfg.cdiv;
    assign div_sel[1] = act_cfg.pdiv;

    for (genvar g = 0; g < 2; g++) begin : g_div
        rate_divider #(.SEL_W(DIV_W)) u_div (
            .clk(clk), .rst_n(rst_n), .sel(div_sel[g]),
            .restart(div_restart), .hold(settling), .ce(ce_vec[g])
        );
    end

    assign core_ce   = ce_vec[0];
    assign peri_ce   = ce_vec[1];
    assign pll_mul   = act_cfg.mul;
    assign clkout_en = 1'b1;
endmodule

// File: rtl/clk_rate_seq_chk.sv
module clk_rate_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_addr,
    input logic       core_ce,
    input logic       peri_ce,
    input logic       cpu_stall,
    input logic       done,
    input logic [1:0] pll_mul
);
    p_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> (!core_ce && !peri_ce));

    p_stall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> $past(wr_en && !wr_addr));

    p_done_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cpu_stall && $past(cpu_stall)));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_mul_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(pll_mul));
endmodule

bind clk_rate_seq clk_rate_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .core_ce(core_ce), .peri_ce(peri_ce), .cpu_stall(cpu_stall),
    .done(done), .pll_mul(pll_mul)
);

// File: tb/tb_clk_rate_seq.sv
`timescale 1ns/1ps
module tb_clk_rate_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        core_ce, peri_ce, cpu_stall, busy, done, clkout_en;
    logic [1:0]  pll_mul;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    clk_rate_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .core_ce(core_ce), .peri_ce(peri_ce),
        .cpu_stall(cpu_stall), .busy(busy), .done(done),
        .pll_mul(pll_mul), .clkout_en(clkout_en)
    );

    typedef struct packed {
        logic [7:0]  start;
        logic [2:0]  psel;
        logic [1:0]  mul;
        logic [1:0]  cdiv;
        logic [1:0]  pdiv;
        logic [15:0] len;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'hF0, 3'd1, 2'b01, 2'b01, 2'b10, 16'd64},
        '{8'hFE, 3'd0, 2'b10, 2'b11, 2'b00, 16'd2},
        '{8'hFF, 3'd0, 2'b11, 2'b00, 2'b01, 16'd1},
        '{8'h00, 3'd2, 2'b00, 2'b10, 2'b11, 16'd4096},
        '{8'hFC, 3'd3, 2'b01, 2'b11, 2'b11, 16'd256},
        '{8'hFF, 3'd7, 2'b10, 2'b01, 2'b00, 16'd16384}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] fword(input logic [1:0] m, input logic [1:0] c, input logic [1:0] p);
        return {10'd0, p, c, m};
    endfunction

    // Count strobes over 12 cycles; stall must stay low.
    task automatic rates(input logic [1:0] c, input logic [1:0] p, input string req);
        int nc = 0, np = 0, ns = 0;
        for (int i = 0; i < 12; i++) begin
            nc += int'(core_ce); np += int'(peri_ce); ns += int'(cpu_stall);
            @(negedge clk);
        end
        check(nc == 12 / (int'(c) + 1), {req, " core rate"}, nc, 12 / (int'(c) + 1));
        check(np == 12 / (int'(p) + 1), {req, " peri rate"}, np, 12 / (int'(p) + 1));
        check(ns == 0, {req, " no stall"}, ns, 0);
    endtask

    // Called right after the pausing write: sample stays on a negedge.
    task automatic pause(input int exp_len, input logic [1:0] old_mul,
                         input logic [1:0] m, input logic [1:0] c, input logic [1:0] p,
                         input bit poke);
        int n = 0, leak = 0, mulbad = 0, clkoff = 0, busybad = 0;
        while (cpu_stall && n < 20000) begin
            n++;
            leak    += int'(core_ce || peri_ce);
            mulbad  += int'(pll_mul != old_mul);
            clkoff  += int'(!clkout_en);
            busybad += int'(!busy || done);
            if (poke && n == 2) begin
                wr_en = 1'b1; wr_addr = 1'b0; wr_data = fword(~m, ~c, ~p);
            end else if (poke && n == 3) begin
                wr_en = 1'b1; wr_addr = 1'b1; wr_data = 16'h00FF;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        check(n == exp_len, "R5 pause length", n, exp_len);
        check(leak == 0, "R4 enables gated", leak, 0);
        check(busybad == 0, "R4 busy high during pause", busybad, 0);
        check(mulbad == 0, "R8 pll_mul held", mulbad, 0);
        check(clkoff == 0, "R9 clkout_en high", clkoff, 0);
        check(done == 1'b1, "R6 done at resume", int'(done), 1);
        check(pll_mul == m, "R6 new mul applied", int'(pll_mul), int'(m));
        check(!busy, "R6 busy low", int'(busy), 0);
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", int'(done), 0);
        rates(c, p, "R6");
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [1:0] cur_mul;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pll_mul == 2'b00, "R1 pll_mul", int'(pll_mul), 0);
        check(!cpu_stall && !busy && !done, "R1 stall/busy/done", int'(cpu_stall), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rates(2'b00, 2'b11, "R1");

        // R3 / R2: divider-only change
        wr(1'b0, fword(2'b00, 2'b10, 2'b01));
        check(pll_mul == 2'b00 && !cpu_stall, "R3 no pause", int'(cpu_stall), 0);
        rates(2'b10, 2'b01, "R3");
        wr(1'b0, fword(2'b00, 2'b01, 2'b00));
        rates(2'b01, 2'b00, "R2");

        // Vector table: multiplier changes
        cur_mul = 2'b00;
        for (int v = 0; v < 6; v++) begin
            wr(1'b1, {5'd0, VECS[v].psel, VECS[v].start});
            wr(1'b0, fword(VECS[v].mul, VECS[v].cdiv, VECS[v].pdiv));
            pause(int'(VECS[v].len), cur_mul, VECS[v].mul, VECS[v].cdiv, VECS[v].pdiv, 1'b0);
            cur_mul = VECS[v].mul;
        end

        // R7: writes during pause ignored (settle setup F0 at /1 = 16 cycles)
        wr(1'b1, 16'h00F0);
        wr(1'b0, fword(2'b01, 2'b11, 2'b01));
        pause(16, cur_mul, 2'b01, 2'b11, 2'b01, 1'b1);
        // R7: settle setup write during pause ignored -> still 16 cycles
        wr(1'b0, fword(2'b11, 2'b00, 2'b10));
        pause(16, 2'b01, 2'b11, 2'b00, 2'b10, 1'b0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule